// File: doc/BRIEF.md
# Debug Coprocessor Register Access Controller

This block is the register side of a debug coprocessor. The core issues move-to and move-from operations on it. Each operation carries a 3-bit opcode2 field, a 4-bit CRm field, the current privilege level, and an indication of whether the core is halted in debug state. The block works out which register is addressed and decides whether the access is allowed. In the same cycle it either completes the access (`acc_done`) or raises an undefined-instruction pulse (`acc_undef`). Write data is stored at the next rising clock edge.

The bank holds the following registers:
- an identification word;
- a status/control word that carries the permission controls;
- a data-transfer pair, in which a read and a write at the same address reach two separate storage elements, each with its own full flag and its own host-side port;
- a fault-address register;
- a vector-catch register;
- two cache/MMU debug control words;
- parameterised banks of breakpoint and watchpoint value/control registers.

When a read names the program counter as its destination, the block returns condition flags. A status read yields status bits 31 to 28 as {N,Z,C,V}. Any other read yields zeros marked unpredictable. The debug behaviour that these registers configure is outside the block.

Top module: `dbg_cp_access`

## Requirements
- R1: Address map. With opcode2=0, CRm 0 selects ID, 1 status, 5 data-transfer, 6 fault-address, 7 vector-catch, 10 and 11 the two cache/MMU debug words. Opcode2 values 4, 5, 6 and 7 select breakpoint value, breakpoint control, watchpoint value and watchpoint control slot CRm. Every other encoding raises `acc_undef`.
- R2: A breakpoint access with CRm >= NUM_BP (default 6) raises `acc_undef`, in every state. So does a watchpoint access with CRm >= NUM_WP (default 2).
- R3: With `acc_halted`=1, every access to a mapped, implemented register completes. Privilege and status bits have no effect.
- R4: Outside debug state in user mode with status bit 12 clear, these complete: ID read, status read, and data-transfer read or write. A status write and any access to other registers raise `acc_undef`.
- R5: Outside debug state in user mode with status bit 12 set, every access raises `acc_undef`.
- R6: Outside debug state in privileged mode, ID, status and data-transfer accesses complete. Any other register completes only when status[15:14]=2'b10. The values 00, 01 and 11 give `acc_undef`.
- R7: ID is read-only, and a write to it raises `acc_undef` even when halted. It reads {NUM_WP-1 in [31:28], NUM_BP-1 in [27:24], zeros, ID_REV in [7:0]}, which is 32'h1500_0015 by default.
- R8: Status bits [27:0] are read/write and reset to 0. Bit 31 and bit 28 read 0. Bit 30 reads the read-direction full flag and bit 29 the write-direction full flag. Writes to bits [31:28] are ignored.
- R9: A completed status read with `acc_to_pc`=1 sets `pc_flags_vld`. It drives `pc_flags`={N,Z,C,V}=status[31:28] and clears `pc_flags_unpred`.
- R10: Any other completed read with `acc_to_pc`=1 sets `pc_flags_vld` and `pc_flags_unpred`, with `pc_flags`=0.
- R11: A core data-transfer write loads the write-direction register and sets `wtr_full`, and a `host_wtr_rd` pulse clears it. A `host_rtr_wr` pulse loads the read-direction register and sets `rtr_full`. A core data-transfer read returns the read-direction register and clears `rtr_full`. When a set and a clear happen in the same cycle, the set wins.
- R12: A rejected access pulses `acc_undef` with `acc_done`=0 and `acc_rdata`=0 in the same cycle, and leaves every register unchanged.
- R13: `acc_rd` and `acc_wr` asserted together raise `acc_undef`.
- R14: Fault-address, vector-catch, the cache/MMU words and the breakpoint and watchpoint registers are 32-bit, reset to 0, and read back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_rd | input | 1 | Move-from (read) request |
| acc_wr | input | 1 | Move-to (write) request |
| acc_op2 | input | 3 | Opcode2 address field |
| acc_crm | input | 4 | CRm address field |
| acc_user | input | 1 | 1 = user mode, 0 = privileged |
| acc_halted | input | 1 | Core halted in debug state |
| acc_to_pc | input | 1 | Read destination is the program counter |
| acc_wdata | input | 32 | Write data |
| acc_done | output | 1 | Access completes this cycle |
| acc_undef | output | 1 | Undefined-instruction pulse |
| acc_rdata | output | 32 | Read data (0 unless a read completes) |
| pc_flags | output | 4 | {N,Z,C,V} for a read into the program counter |
| pc_flags_vld | output | 1 | pc_flags apply this cycle |
| pc_flags_unpred | output | 1 | Flags are unpredictable (modelled as 0) |
| host_rtr_wr | input | 1 | Host writes the read-direction transfer register |
| host_rtr_data | input | 32 | Host write data |
| host_wtr_rd | input | 1 | Host consumes the write-direction transfer register |
| host_wtr_data | output | 32 | Write-direction transfer register contents |
| rtr_full | output | 1 | Read-direction register holds unread data |
| wtr_full | output | 1 | Write-direction register holds unconsumed data |

## Verification
The hardest case to reach from the ports is a write-to-read conflict on the transfer pair: the host loads the read-direction register in the same cycle that the core reads it. The bench first fills the register from the host side. It then issues a core read while pulsing `host_rtr_wr` in that same cycle. It checks that the old word comes back, that the full flag stays set, and that a second read returns the new word. The permission lattice is covered by walking the status word through every debug-mode value and the user-disable bit, using privileged writes between probes. The program-counter flag path is checked with both full flags in known states.

// File: rtl/dbgacc_pkg.sv
package dbgacc_pkg;

    localparam int DW = 32;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ID,
        SEL_STAT,
        SEL_DTR,
        SEL_FADDR,
        SEL_VCATCH,
        SEL_CDBG0,
        SEL_CDBG1,
        SEL_BVAL,
        SEL_BCTL,
        SEL_WVAL,
        SEL_WCTL
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_HALT_A  = 2'b01,
        MODE_MON     = 2'b10,
        MODE_HALT_B  = 2'b11
    } dbg_mode_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [3:0] slot;
    } dec_t;

    typedef struct packed {
        logic       rd;
        logic       wr;
        logic [2:0] op2;
        logic [3:0] crm;
        logic       user;
        logic       halted;
        logic       to_pc;
    } req_t;

    // status word bit positions
    localparam int ST_UDIS   = 12;
    localparam int ST_MODE_L = 14;
    localparam int ST_WTRF   = 29;
    localparam int ST_RTRF   = 30;
    localparam int ST_STORE  = 28;   // bits [27:0] are stored

    function automatic dec_t decode_addr(input logic [2:0] op2,
                                         input logic [3:0] crm,
                                         input int         nbp,
                                         input int         nwp);
        dec_t d;
        d.sel  = SEL_NONE;
        d.slot = crm;
        case (op2)
            3'd0: begin
                case (crm)
                    4'd0:    d.sel = SEL_ID;
                    4'd1:    d.sel = SEL_STAT;
                    4'd5:    d.sel = SEL_DTR;
                    4'd6:    d.sel = SEL_FADDR;
                    4'd7:    d.sel = SEL_VCATCH;
                    4'd10:   d.sel = SEL_CDBG0;
                    4'd11:   d.sel = SEL_CDBG1;
                    default: d.sel = SEL_NONE;
                endcase
            end
            3'd4: if (int'(crm) < nbp) d.sel = SEL_BVAL;
            3'd5: if (int'(crm) < nbp) d.sel = SEL_BCTL;
            3'd6: if (int'(crm) < nwp) d.sel = SEL_WVAL;
            3'd7: if (int'(crm) < nwp) d.sel = SEL_WCTL;
            default: d.sel = SEL_NONE;
        endcase
        return d;
    endfunction

    // registers reachable from user mode and unlocked in privileged mode
    function automatic logic is_open_reg(input reg_sel_e s);
        return (s == SEL_ID) || (s == SEL_STAT) || (s == SEL_DTR);
    endfunction

endpackage

// File: rtl/dbgacc_decode.sv
module dbgacc_decode
    import dbgacc_pkg::*;
#(
    parameter int NUM_BP = 6,
    parameter int NUM_WP = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  req_t      req,
    input  logic      udis,
    input  dbg_mode_e mode,
    output dec_t      dec,
    output logic      grant,
    output logic      undef
);

    logic active;
    logic enc_ok;
    logic perm_ok;

    always_comb begin
        active = req.rd | req.wr;
        dec    = decode_addr(req.op2, req.crm, NUM_BP, NUM_WP);
        enc_ok = (dec.sel != SEL_NONE)
               && !(dec.sel == SEL_ID && req.wr)
               && !(req.rd && req.wr);
        if (req.halted)
            perm_ok = 1'b1;
        else if (req.user)
            perm_ok = !udis && is_open_reg(dec.sel)
                      && !(dec.sel == SEL_STAT && req.wr);
        else
            perm_ok = is_open_reg(dec.sel) || (mode == MODE_MON);
        grant = active && enc_ok && perm_ok;
        undef = active && !grant;
    end

    // R5
    user_udis_chk: assert property (@(posedge clk) disable iff (rst)
        (req.user && !req.halted && udis) |-> !grant);

    // R6
    priv_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (grant && !req.halted && !is_open_reg(dec.sel)) |-> (mode == MODE_MON && !req.user));

    // R13
    both_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.wr) |-> undef);

endmodule

// File: rtl/dbgacc_xfer.sv
module dbgacc_xfer
    import dbgacc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          core_wr,
    input  logic          core_rd,
    input  logic [DW-1:0] core_wdata,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    output logic [DW-1:0] rtr_q,
    output logic [DW-1:0] wtr_q,
    output logic          rtr_full,
    output logic          wtr_full
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rtr_q    <= '0;
            wtr_q    <= '0;
            rtr_full <= 1'b0;
            wtr_full <= 1'b0;
        end else begin
            if (host_wr) begin
                rtr_q    <= host_wdata;
                rtr_full <= 1'b1;
            end else if (core_rd) begin
                rtr_full <= 1'b0;
            end
            if (core_wr) begin
                wtr_q    <= core_wdata;
                wtr_full <= 1'b1;
            end else if (host_rd) begin
                wtr_full <= 1'b0;
            end
        end
    end

    // R11
    wtr_set_chk: assert property (@(posedge clk) disable iff (rst)
        core_wr |=> (wtr_full && wtr_q == $past(core_wdata)));

    // R11
    rtr_set_chk: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> (rtr_full && rtr_q == $past(host_wdata)));

    // R11
    rtr_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (core_rd && !host_wr) |=> !rtr_full);

endmodule

// File: rtl/dbgacc_bank.sv
module dbgacc_bank
    import dbgacc_pkg::*;
#(
    parameter int N = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          val_we,
    input  logic          ctl_we,
    input  logic [3:0]    idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_val,
    output logic [DW-1:0] rd_ctl
);

    logic [DW-1:0] val_q [N];
    logic [DW-1:0] ctl_q [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                val_q[g] <= '0;
                ctl_q[g] <= '0;
            end else if (idx == 4'(g)) begin
                if (val_we) val_q[g] <= wdata;
                if (ctl_we) ctl_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        rd_ctl = '0;
        for (int i = 0; i < N; i++) begin
            if (idx == 4'(i)) begin
                rd_val = val_q[i];
                rd_ctl = ctl_q[i];
            end
        end
    end

endmodule

// File: rtl/dbg_cp_access.sv
module dbg_cp_access
    import dbgacc_pkg::*;
#(
    parameter int         NUM_BP = 6,
    parameter int         NUM_WP = 2,
    parameter logic [7:0] ID_REV = 8'h15
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_rd,
    input  logic        acc_wr,
    input  logic [2:0]  acc_op2,
    input  logic [3:0]  acc_crm,
    input  logic        acc_user,
    input  logic        acc_halted,
    input  logic        acc_to_pc,
    input  logic [31:0] acc_wdata,
    output logic        acc_done,
    output logic        acc_undef,
    output logic [31:0] acc_rdata,
    output logic [3:0]  pc_flags,
    output logic        pc_flags_vld,
    output logic        pc_flags_unpred,
    input  logic        host_rtr_wr,
    input  logic [31:0] host_rtr_data,
    input  logic        host_wtr_rd,
    output logic [31:0] host_wtr_data,
    output logic        rtr_full,
    output logic        wtr_full
);

    localparam logic [DW-1:0] ID_VALUE =
        {4'(NUM_WP - 1), 4'(NUM_BP - 1), 16'h0000, ID_REV};

    req_t          req;
    dec_t          dec;
    logic          grant;
    logic          rd_ok;
    logic          wr_ok;
    logic [ST_STORE-1:0] stat_q;
    logic [DW-1:0] stat_view;
    logic [DW-1:0] faddr_q, vcatch_q, cdbg0_q, cdbg1_q;
    logic [DW-1:0] rtr_q;
    logic [DW-1:0] bp_val, bp_ctl, wp_val, wp_ctl;
    dbg_mode_e     mode;

    always_comb begin
        req.rd     = acc_rd;
        req.wr     = acc_wr;
        req.op2    = acc_op2;
        req.crm    = acc_crm;
        req.user   = acc_user;
        req.halted = acc_halted;
        req.to_pc  = acc_to_pc;
        mode       = dbg_mode_e'(stat_q[ST_MODE_L+1:ST_MODE_L]);
    end

    dbgacc_decode #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .udis  (stat_q[ST_UDIS]),
        .mode  (mode),
        .dec   (dec),
        .grant (grant),
        .undef (acc_undef)
    );

    assign rd_ok    = grant & acc_rd;
    assign wr_ok    = grant & acc_wr;
    assign acc_done = grant;

    dbgacc_xfer u_xfer (
        .clk        (clk),
        .rst        (rst),
        .core_wr    (wr_ok && dec.sel == SEL_DTR),
        .core_rd    (rd_ok && dec.sel == SEL_DTR),
        .core_wdata (acc_wdata),
        .host_wr    (host_rtr_wr),
        .host_wdata (host_rtr_data),
        .host_rd    (host_wtr_rd),
        .rtr_q      (rtr_q),
        .wtr_q      (host_wtr_data),
        .rtr_full   (rtr_full),
        .wtr_full   (wtr_full)
    );

    dbgacc_bank #(.N(NUM_BP)) u_bp (
        .clk    (clk),
        .rst    (rst),
        .val_we (wr_ok && dec.sel == SEL_BVAL),
        .ctl_we (wr_ok && dec.sel == SEL_BCTL),
        .idx    (dec.slot),
        .wdata  (acc_wdata),
        .rd_val (bp_val),
        .rd_ctl (bp_ctl)
    );

    dbgacc_bank #(.N(NUM_WP)) u_wp (
        .clk    (clk),
        .rst    (rst),
        .val_we (wr_ok && dec.sel == SEL_WVAL),
        .ctl_we (wr_ok && dec.sel == SEL_WCTL),
        .idx    (dec.slot),
        .wdata  (acc_wdata),
        .rd_val (wp_val),
        .rd_ctl (wp_ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q   <= '0;
            faddr_q  <= '0;
            vcatch_q <= '0;
            cdbg0_q  <= '0;
            cdbg1_q  <= '0;
        end else if (wr_ok) begin
            case (dec.sel)
                SEL_STAT:   stat_q   <= acc_wdata[ST_STORE-1:0];
                SEL_FADDR:  faddr_q  <= acc_wdata;
                SEL_VCATCH: vcatch_q <= acc_wdata;
                SEL_CDBG0:  cdbg0_q  <= acc_wdata;
                SEL_CDBG1:  cdbg1_q  <= acc_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        stat_view = {1'b0, rtr_full, wtr_full, 1'b0, stat_q};
        acc_rdata = '0;
        if (rd_ok) begin
            case (dec.sel)
                SEL_ID:     acc_rdata = ID_VALUE;
                SEL_STAT:   acc_rdata = stat_view;
                SEL_DTR:    acc_rdata = rtr_q;
                SEL_FADDR:  acc_rdata = faddr_q;
                SEL_VCATCH: acc_rdata = vcatch_q;
                SEL_CDBG0:  acc_rdata = cdbg0_q;
                SEL_CDBG1:  acc_rdata = cdbg1_q;
                SEL_BVAL:   acc_rdata = bp_val;
                SEL_BCTL:   acc_rdata = bp_ctl;
                SEL_WVAL:   acc_rdata = wp_val;
                SEL_WCTL:   acc_rdata = wp_ctl;
                default:    acc_rdata = '0;
            endcase
        end
        pc_flags_vld    = rd_ok && acc_to_pc;
        pc_flags_unpred = pc_flags_vld && (dec.sel != SEL_STAT);
        pc_flags        = (pc_flags_vld && dec.sel == SEL_STAT) ?
                          stat_view[31:28] : 4'b0000;
    end

    // R12
    reject_out_chk: assert property (@(posedge clk) disable iff (rst)
        acc_undef |-> (!acc_done && acc_rdata == '0 && !pc_flags_vld));

    // R12
    reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        acc_undef |=> ($stable(stat_q) && $stable(faddr_q) && $stable(vcatch_q)
                       && $stable(cdbg0_q) && $stable(cdbg1_q)));

    // R4
    user_scope_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_done && acc_user && !acc_halted) |->
            (is_open_reg(dec.sel) && !(dec.sel == SEL_STAT && acc_wr)));

    // R9
    pc_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_flags_vld && !pc_flags_unpred) |->
            (pc_flags == {1'b0, rtr_full, wtr_full, 1'b0}));

endmodule

// File: tb/tb_dbg_cp_access.sv
module tb_dbg_cp_access;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_rd, acc_wr;
    logic [2:0]  acc_op2;
    logic [3:0]  acc_crm;
    logic        acc_user, acc_halted, acc_to_pc;
    logic [31:0] acc_wdata;
    logic        acc_done, acc_undef;
    logic [31:0] acc_rdata;
    logic [3:0]  pc_flags;
    logic        pc_flags_vld, pc_flags_unpred;
    logic        host_rtr_wr;
    logic [31:0] host_rtr_data;
    logic        host_wtr_rd;
    logic [31:0] host_wtr_data;
    logic        rtr_full, wtr_full;

    int checks = 0;
    int errors = 0;

    logic        g_done, g_undef, g_fv, g_fu;
    logic [31:0] g_rdata;
    logic [3:0]  g_flags;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_cp_access dut (
        .clk(clk), .rst(rst),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_op2(acc_op2), .acc_crm(acc_crm),
        .acc_user(acc_user), .acc_halted(acc_halted), .acc_to_pc(acc_to_pc),
        .acc_wdata(acc_wdata),
        .acc_done(acc_done), .acc_undef(acc_undef), .acc_rdata(acc_rdata),
        .pc_flags(pc_flags), .pc_flags_vld(pc_flags_vld),
        .pc_flags_unpred(pc_flags_unpred),
        .host_rtr_wr(host_rtr_wr), .host_rtr_data(host_rtr_data),
        .host_wtr_rd(host_wtr_rd), .host_wtr_data(host_wtr_data),
        .rtr_full(rtr_full), .wtr_full(wtr_full)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // one access: drive at negedge, sample combinational outputs, commit at posedge
    task automatic acc(input logic rd, input logic wr, input logic [2:0] op2,
                       input logic [3:0] crm, input logic user, input logic halt,
                       input logic pc, input logic [31:0] wd);
        @(negedge clk);
        acc_rd = rd; acc_wr = wr; acc_op2 = op2; acc_crm = crm;
        acc_user = user; acc_halted = halt; acc_to_pc = pc; acc_wdata = wd;
        #2;
        g_done = acc_done; g_undef = acc_undef; g_rdata = acc_rdata;
        g_flags = pc_flags; g_fv = pc_flags_vld; g_fu = pc_flags_unpred;
        @(posedge clk);
        #1;
        acc_rd = 1'b0; acc_wr = 1'b0; acc_to_pc = 1'b0;
    endtask

    task automatic set_status(input logic [31:0] v);
        acc(0, 1, 3'd0, 4'd1, 0, 0, 0, v);
    endtask

    task automatic expect_undef(input string tag);
        chk({tag, " undef"}, {31'd0, g_undef}, 32'd1);
        chk({tag, " rdata0"}, g_rdata, 32'd0);
    endtask

    task automatic t_reset;
        chk("R11 reset rtr_full", {31'd0, rtr_full}, 32'd0);
        chk("R11 reset wtr_full", {31'd0, wtr_full}, 32'd0);
        acc(1, 0, 3'd0, 4'd1, 0, 0, 0, 0);
        chk("R8 reset status", g_rdata, 32'd0);
        acc(1, 0, 3'd0, 4'd0, 0, 0, 0, 0);
        chk("R7 id value", g_rdata, 32'h1500_0015);
    endtask

    task automatic t_map;
        set_status(32'h0000_8000);          // monitor mode
        acc(1, 0, 3'd0, 4'd2, 0, 0, 0, 0);   expect_undef("R1 op2=0 crm2");
        acc(1, 0, 3'd1, 4'd0, 0, 0, 0, 0);   expect_undef("R1 op2=1");
        acc(0, 1, 3'd3, 4'd0, 0, 0, 0, 1);   expect_undef("R1 op2=3");
        acc(1, 1, 3'd0, 4'd1, 0, 0, 0, 0);   expect_undef("R13 rd+wr");
        acc(0, 1, 3'd0, 4'd6, 0, 0, 0, 32'hA0A0_0006);
        chk("R14 faddr wr done", {31'd0, g_done}, 32'd1);
        acc(0, 1, 3'd0, 4'd7, 0, 0, 0, 32'hB0B0_0007);
        acc(0, 1, 3'd0, 4'd10, 0, 0, 0, 32'hC0C0_000A);
        acc(0, 1, 3'd0, 4'd11, 0, 0, 0, 32'hD0D0_000B);
        acc(0, 1, 3'd4, 4'd3, 0, 0, 0, 32'h1111_0003);
        acc(0, 1, 3'd5, 4'd3, 0, 0, 0, 32'h2222_0003);
        acc(0, 1, 3'd6, 4'd1, 0, 0, 0, 32'h3333_0001);
        acc(0, 1, 3'd7, 4'd1, 0, 0, 0, 32'h4444_0001);
        acc(1, 0, 3'd0, 4'd6, 0, 0, 0, 0);   chk("R14 faddr", g_rdata, 32'hA0A0_0006);
        acc(1, 0, 3'd0, 4'd7, 0, 0, 0, 0);   chk("R14 vcatch", g_rdata, 32'hB0B0_0007);
        acc(1, 0, 3'd0, 4'd10, 0, 0, 0, 0);  chk("R14 cdbg0", g_rdata, 32'hC0C0_000A);
        acc(1, 0, 3'd0, 4'd11, 0, 0, 0, 0);  chk("R14 cdbg1", g_rdata, 32'hD0D0_000B);
        acc(1, 0, 3'd4, 4'd3, 0, 0, 0, 0);   chk("R14 bval3", g_rdata, 32'h1111_0003);
        acc(1, 0, 3'd5, 4'd3, 0, 0, 0, 0);   chk("R14 bctl3", g_rdata, 32'h2222_0003);
        acc(1, 0, 3'd6, 4'd1, 0, 0, 0, 0);   chk("R14 wval1", g_rdata, 32'h3333_0001);
        acc(1, 0, 3'd7, 4'd1, 0, 0, 0, 0);   chk("R14 wctl1", g_rdata, 32'h4444_0001);
        acc(1, 0, 3'd4, 4'd2, 0, 0, 0, 0);   chk("R14 bval2 untouched", g_rdata, 32'd0);
    endtask

    task automatic t_slots;
        acc(1, 0, 3'd4, 4'd6, 0, 0, 0, 0);   expect_undef("R2 bp slot6");
        acc(1, 0, 3'd4, 4'd5, 0, 0, 0, 0);
        chk("R2 bp slot5 done", {31'd0, g_done}, 32'd1);
        acc(1, 0, 3'd6, 4'd2, 0, 0, 0, 0);   expect_undef("R2 wp slot2");
        acc(0, 1, 3'd7, 4'd2, 0, 1, 0, 5);   expect_undef("R2 wp slot2 halted");
        acc(0, 1, 3'd5, 4'd15, 0, 1, 0, 5);  expect_undef("R2 bp slot15 halted");
    endtask

    task automatic t_priv_modes;
        logic [31:0] modes [3];
        modes[0] = 32'h0000_0000; modes[1] = 32'h0000_4000; modes[2] = 32'h0000_C000;
        for (int i = 0; i < 3; i++) begin
            set_status(modes[i]);
            acc(1, 0, 3'd0, 4'd6, 0, 0, 0, 0);  expect_undef("R6 locked faddr rd");
            acc(1, 0, 3'd0, 4'd0, 0, 0, 0, 0);
            chk("R6 id rd open", {31'd0, g_done}, 32'd1);
            acc(1, 0, 3'd0, 4'd1, 0, 0, 0, 0);
            chk("R6 status rd open", g_rdata, modes[i]);
        end
    endtask

    task automatic t_user;
        set_status(32'h0000_8000);
        acc(1, 0, 3'd0, 4'd1, 1, 0, 0, 0);
        chk("R4 user status rd", g_rdata, 32'h0000_8000);
        acc(0, 1, 3'd0, 4'd1, 1, 0, 0, 0);   expect_undef("R4 user status wr");
        acc(1, 0, 3'd0, 4'd1, 0, 0, 0, 0);
        chk("R4 status unchanged", g_rdata, 32'h0000_8000);
        acc(1, 0, 3'd0, 4'd0, 1, 0, 0, 0);   chk("R4 user id", g_rdata, 32'h1500_0015);
        acc(1, 0, 3'd0, 4'd6, 1, 0, 0, 0);   expect_undef("R4 user faddr");
        acc(0, 1, 3'd0, 4'd5, 1, 0, 0, 32'h5555_AAAA);
        chk("R4 user dtr wr", {31'd0, g_done}, 32'd1);
        chk("R4 dtr data", host_wtr_data, 32'h5555_AAAA);
        @(negedge clk); host_wtr_rd = 1'b1; @(negedge clk); host_wtr_rd = 1'b0;
        set_status(32'h0000_9000);          // user disable + monitor
        acc(1, 0, 3'd0, 4'd1, 1, 0, 0, 0);   expect_undef("R5 user status rd");
        acc(1, 0, 3'd0, 4'd0, 1, 0, 0, 0);   expect_undef("R5 user id rd");
        acc(0, 1, 3'd0, 4'd5, 1, 0, 0, 1);   expect_undef("R5 user dtr wr");
        chk("R5 wtr_full untouched", {31'd0, wtr_full}, 32'd0);
    endtask

    task automatic t_halt;
        // status still has user-disable set, mode monitor
        acc(0, 1, 3'd0, 4'd6, 1, 1, 0, 32'h6666_0006);
        chk("R3 halted user faddr wr", {31'd0, g_done}, 32'd1);
        acc(1, 0, 3'd0, 4'd6, 1, 1, 0, 0);
        chk("R3 halted readback", g_rdata, 32'h6666_0006);
        acc(0, 1, 3'd0, 4'd1, 1, 1, 0, 32'h0000_0000);
        chk("R3 halted user status wr", {31'd0, g_done}, 32'd1);
        acc(0, 1, 3'd4, 4'd0, 0, 1, 0, 32'h7777_0000);
        chk("R3 halted mode00 bval", {31'd0, g_done}, 32'd1);
        acc(0, 1, 3'd0, 4'd0, 0, 1, 0, 1);   expect_undef("R7 id write halted");
    endtask

    task automatic t_status_bits;
        set_status(32'hFFFF_FFFF);
        acc(1, 0, 3'd0, 4'd1, 0, 0, 0, 0);
        chk("R8 status top ignored", g_rdata, 32'h0FFF_FFFF);
        set_status(32'h0000_0000);
    endtask

    task automatic t_dtr;
        acc(0, 1, 3'd0, 4'd5, 0, 0, 0, 32'hCAFE_0001);
        chk("R11 wtr_full set", {31'd0, wtr_full}, 32'd1);
        acc(1, 0, 3'd0, 4'd1, 0, 0, 0, 0);
        chk("R8 status wtrf bit29", g_rdata, 32'h2000_0000);
        @(negedge clk); host_rtr_wr = 1'b1; host_rtr_data = 32'hBEEF_0002;
        @(negedge clk); host_rtr_wr = 1'b0;
        chk("R11 rtr_full set", {31'd0, rtr_full}, 32'd1);
        // R9: rtr full, wtr full -> Z=1, C=1
        acc(1, 0, 3'd0, 4'd1, 0, 0, 1, 0);
        chk("R9 flags both full", {28'd0, g_flags}, 32'h6);
        chk("R9 vld/unpred", {30'd0, g_fv, g_fu}, 32'h2);
        @(negedge clk); host_wtr_rd = 1'b1; @(negedge clk); host_wtr_rd = 1'b0;
        chk("R11 wtr_full cleared", {31'd0, wtr_full}, 32'd0);
        acc(1, 0, 3'd0, 4'd1, 0, 0, 1, 0);
        chk("R9 flags rtr only", {28'd0, g_flags}, 32'h4);
        // R10: pc-destination read of non-status
        acc(1, 0, 3'd0, 4'd0, 0, 0, 1, 0);
        chk("R10 flags zero", {28'd0, g_flags}, 32'h0);
        chk("R10 vld/unpred", {30'd0, g_fv, g_fu}, 32'h3);
        // conflict: core read while host writes
        @(negedge clk);
        acc_rd = 1; acc_wr = 0; acc_op2 = 3'd0; acc_crm = 4'd5; acc_user = 0;
        acc_halted = 0; acc_to_pc = 0;
        host_rtr_wr = 1'b1; host_rtr_data = 32'hF00D_0003;
        #2;
        chk("R11 conflict old data", acc_rdata, 32'hBEEF_0002);
        @(posedge clk); #1;
        acc_rd = 0; host_rtr_wr = 1'b0;
        chk("R11 conflict set wins", {31'd0, rtr_full}, 32'd1);
        acc(1, 0, 3'd0, 4'd5, 0, 0, 0, 0);
        chk("R11 new data", g_rdata, 32'hF00D_0003);
        chk("R11 rtr_full cleared", {31'd0, rtr_full}, 32'd0);
    endtask

    task automatic t_reject;
        set_status(32'h0000_8000);
        acc(0, 1, 3'd0, 4'd7, 0, 0, 0, 32'h1234_5678);
        set_status(32'h0000_0000);
        acc(0, 1, 3'd0, 4'd7, 0, 0, 0, 32'hDEAD_DEAD);
        expect_undef("R12 locked write");
        chk("R12 no done", {31'd0, g_done}, 32'd0);
        acc(1, 0, 3'd0, 4'd7, 0, 1, 0, 0);
        chk("R12 vcatch unchanged", g_rdata, 32'h1234_5678);
    endtask

    initial begin
        rst = 1'b1;
        acc_rd = 0; acc_wr = 0; acc_op2 = 0; acc_crm = 0; acc_user = 0;
        acc_halted = 0; acc_to_pc = 0; acc_wdata = 0;
        host_rtr_wr = 0; host_rtr_data = 0; host_wtr_rd = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_map();
        t_slots();
        t_priv_modes();
        t_user();
        t_halt();
        t_status_bits();
        t_dtr();
        t_reject();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule